// File: doc/BRIEF.md
# Switchable-Depth UART Receive Buffer

This block stores received characters for a 16550-style serial controller. It runs in one of two modes. With the FIFO disabled it acts as a single holding register. With the FIFO enabled it is a first-in first-out queue of `DEPTH` entries, 16 by default. Software selects the mode through a write-only control byte. The block keeps a filtered copy of that byte so that neighbouring logic can decode the DMA-mode and trigger-level fields.

Characters arrive on a push port. The `push_lpbk_i` qualifier marks a character that comes from the internal loopback path rather than from the line. Reads of the data register drive the pop port. The head character is always visible on `pop_data_o`. The occupancy count, empty and full are outputs. The full output lets the upstream source stall instead of losing data. A sticky overrun flag records a loopback character that was rejected, and a line-status read clears it.

Every change of mode empties the buffer. A receive-reset request in FIFO mode also empties it. A flush has priority: any push or pop in the same cycle is ignored.

Top module: `uart_rx_buf`

## Requirements
- R1: After reset the count is 0, `empty_o` is 1, `full_o` is 0, `overrun_o` is 0, `pop_data_o` is 0 and `ctl_o` is 0x00, so the capacity is one entry.
- R2: The capacity is `DEPTH` when `ctl_o` bit 0 is 1 and 1 when bit 0 is 0. `full_o` is 1 exactly when the count equals the capacity, and the count never exceeds it.
- R3: A control write whose bit 0 differs from the stored bit 0 empties the buffer on the next cycle and sets the new capacity. Any push or pop in that cycle is ignored.
- R4: A control write with bit 0 clear stores 0x00, whatever its other bits are.
- R5: A control write with bit 0 set and bit 1 (receive reset) set empties the buffer and leaves the capacity at `DEPTH`.
- R6: A control write with bit 0 set stores the written byte ANDed with 0xC9. This keeps bit 0 (enable), bit 3 (DMA mode) and bits 7:6 (receive trigger).
- R7: A push while `full_o` is 1 is rejected, even if a pop happens in the same cycle. Stored characters and their order are unchanged.
- R8: A rejected push with `push_lpbk_i` set raises `overrun_o`, and a rejected push from the line does not. `ovr_clr_i` clears the flag. If a set and a clear occur in the same cycle, the set wins.
- R9: A pop while empty has no effect, and `pop_data_o` reads 0 while empty.
- R10: Characters leave in arrival order across any number of pointer wraps at the current capacity.
- R11: A push and a pop in the same cycle on a buffer that is neither empty nor full leave the count unchanged. The pushed character is queued behind the rest.
- R12: A control write with bit 0 set, bit 1 clear and the stored bit 0 already set leaves the contents and count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_we_i | input | 1 | Control byte write strobe |
| ctl_data_i | input | 8 | Control byte written |
| push_i | input | 1 | Push a character |
| push_lpbk_i | input | 1 | Pushed character comes from loopback |
| push_data_i | input | DATA_W | Character to push |
| pop_i | input | 1 | Pop the head character (data register read) |
| ovr_clr_i | input | 1 | Clear overrun (line status read) |
| pop_data_o | output | DATA_W | Head character, 0 when empty |
| count_o | output | $clog2(DEPTH+1) | Occupancy |
| empty_o | output | 1 | Buffer empty |
| full_o | output | 1 | Occupancy equals capacity |
| overrun_o | output | 1 | Sticky loopback overrun |
| ctl_o | output | 8 | Filtered stored control byte |

## Verification
The bench builds the block with `DEPTH` = 4 so that the full boundary and the pointer wrap come up every few operations. This lets a long pseudo-random run of pushes, pops, clears and control writes cross the wrap point hundreds of times in both modes, and the bench compares every output against a queue model after each cycle. It also writes all 256 control byte values in turn, which covers the filter mask, the enable-clear rule and the flush on every mode change, each from both stored modes.

// File: rtl/uart_rx_buf_pkg.sv
package uart_rx_buf_pkg;
  localparam int unsigned CTL_W      = 8;
  localparam int unsigned CTL_EN     = 0;
  localparam int unsigned CTL_RXRST  = 1;
  localparam int unsigned CTL_DMA    = 3;
  localparam int unsigned CTL_TRG_LO = 6;
  localparam int unsigned CTL_TRG_HI = 7;
  localparam logic [CTL_W-1:0] CTL_KEEP =
    CTL_W'((1 << CTL_EN) | (1 << CTL_DMA) | (1 << CTL_TRG_LO) | (1 << CTL_TRG_HI));
endpackage

// File: rtl/uart_rx_buf_ctl.sv
module uart_rx_buf_ctl
  import uart_rx_buf_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CTL_W-1:0] wdata_i,
  output logic [CTL_W-1:0] ctl_o,
  output logic             flush_o,
  output logic             fifo_en_o
);
  logic [CTL_W-1:0] ctl_q;

  // mode toggle or receive reset in FIFO mode empties the store
  assign flush_o = we_i & ((wdata_i[CTL_EN] ^ ctl_q[CTL_EN]) |
                           (wdata_i[CTL_EN] & wdata_i[CTL_RXRST]));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctl_q <= '0;
    else if (we_i) ctl_q <= wdata_i[CTL_EN] ? (wdata_i & CTL_KEEP) : '0;
  end

  assign ctl_o     = ctl_q;
  assign fifo_en_o = ctl_q[CTL_EN];
endmodule

// File: rtl/uart_rx_buf_store.sv
module uart_rx_buf_store #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              fifo_en_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] head_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              full_o,
  output logic              empty_o,
  output logic              push_rej_o
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  cnt_q, cap;
  logic              push_ok, pop_ok;

  assign cap     = fifo_en_i ? CNT_W'(DEPTH) : CNT_W'(1);
  assign full_o  = (cnt_q == cap);
  assign empty_o = (cnt_q == '0);
  assign push_ok = push_i & ~full_o & ~flush_i;
  assign pop_ok  = pop_i & ~empty_o & ~flush_i;
  assign push_rej_o = push_i & full_o & ~flush_i;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p,
                                               input logic [CNT_W-1:0] c);
    if (CNT_W'(p) + CNT_W'(1) >= c) return '0;
    return p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else if (flush_i) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_ok) wr_ptr <= ptr_inc(wr_ptr, cap);
      if (pop_ok)  rd_ptr <= ptr_inc(rd_ptr, cap);
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) mem[wr_ptr] <= push_data_i;
  end

  assign head_o  = empty_o ? '0 : mem[rd_ptr];
  assign count_o = cnt_q;
endmodule

// File: rtl/uart_rx_buf.sv
module uart_rx_buf
  import uart_rx_buf_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctl_we_i,
  input  logic [CTL_W-1:0]  ctl_data_i,
  input  logic              push_i,
  input  logic              push_lpbk_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  input  logic              ovr_clr_i,
  output logic [DATA_W-1:0] pop_data_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              empty_o,
  output logic              full_o,
  output logic              overrun_o,
  output logic [CTL_W-1:0]  ctl_o
);
  logic flush, fifo_en, push_rej, ovr_q;

  uart_rx_buf_ctl u_ctl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (ctl_we_i),
    .wdata_i   (ctl_data_i),
    .ctl_o     (ctl_o),
    .flush_o   (flush),
    .fifo_en_o (fifo_en)
  );

  uart_rx_buf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (flush),
    .fifo_en_i   (fifo_en),
    .push_i      (push_i),
    .push_data_i (push_data_i),
    .pop_i       (pop_i),
    .head_o      (pop_data_o),
    .count_o     (count_o),
    .full_o      (full_o),
    .empty_o     (empty_o),
    .push_rej_o  (push_rej)
  );

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     ovr_q <= 1'b0;
    else if (push_rej & push_lpbk_i) ovr_q <= 1'b1;
    else if (ovr_clr_i)              ovr_q <= 1'b0;
  end

  assign overrun_o = ovr_q;
endmodule

// File: rtl/uart_rx_buf_chk.sv
module uart_rx_buf_chk #(
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ctl_we_i,
  input logic [7:0]       ctl_data_i,
  input logic             push_i,
  input logic             push_lpbk_i,
  input logic             pop_i,
  input logic [CNT_W-1:0] count_o,
  input logic             empty_o,
  input logic             full_o,
  input logic             overrun_o,
  input logic [7:0]       ctl_o
);
  // R2
  cap_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= (ctl_o[0] ? CNT_W'(DEPTH) : CNT_W'(1)));

  // R3
  mode_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_we_i && (ctl_data_i[0] != ctl_o[0]) |=> count_o == '0);

  // R4
  en_clear_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_we_i && !ctl_data_i[0] |=> ctl_o == 8'h00);

  // R5
  rx_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_we_i && ctl_data_i[0] && ctl_data_i[1] |=> count_o == '0 && ctl_o[0]);

  // R7
  full_reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && full_o && !pop_i && !ctl_we_i |=> $stable(count_o));

  // R8
  overrun_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && push_lpbk_i && full_o && !ctl_we_i |=> overrun_o);

  // R9
  empty_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && empty_o && !push_i && !ctl_we_i |=> count_o == '0);

  // R11
  same_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && pop_i && !empty_o && !full_o && !ctl_we_i |=> $stable(count_o));
endmodule

bind uart_rx_buf uart_rx_buf_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ctl_we_i    (ctl_we_i),
  .ctl_data_i  (ctl_data_i),
  .push_i      (push_i),
  .push_lpbk_i (push_lpbk_i),
  .pop_i       (pop_i),
  .count_o     (count_o),
  .empty_o     (empty_o),
  .full_o      (full_o),
  .overrun_o   (overrun_o),
  .ctl_o       (ctl_o)
);

// File: tb/uart_rx_buf_test.sv
`timescale 1ns/1ps
module uart_rx_buf_test;
  localparam int unsigned DW = 8;
  localparam int unsigned DP = 4;
  localparam int unsigned CW = $clog2(DP + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_we = 1'b0, push = 1'b0, lpbk = 1'b0, pop = 1'b0, clr = 1'b0;
  logic [7:0] ctl_d = '0;
  logic [DW-1:0] pdata = '0;
  logic [DW-1:0] head;
  logic [CW-1:0] cnt;
  logic empty, full, ovr;
  logic [7:0] ctl;

  int errors = 0, checks = 0;
  bit done = 0;

  byte unsigned mq[$];
  logic [7:0] m_ctl = 8'h00;
  bit m_ov = 0;
  logic [15:0] lf = 16'hACE1;

  always #2 clk = ~clk;

  uart_rx_buf #(.DATA_W(DW), .DEPTH(DP)) uut (
    .clk_i(clk), .rst_ni(rst_n), .ctl_we_i(ctl_we), .ctl_data_i(ctl_d),
    .push_i(push), .push_lpbk_i(lpbk), .push_data_i(pdata), .pop_i(pop),
    .ovr_clr_i(clr), .pop_data_o(head), .count_o(cnt), .empty_o(empty),
    .full_o(full), .overrun_o(ovr), .ctl_o(ctl)
  );

  task automatic cmp(input string rq, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic chk(input string rq);
    int cap = m_ctl[0] ? DP : 1;
    cmp(rq, "count", int'(cnt), mq.size());
    cmp(rq, "empty", int'(empty), int'(mq.size() == 0));
    cmp(rq, "full", int'(full), int'(mq.size() == cap));
    cmp(rq, "head", int'(head), (mq.size() > 0) ? int'(mq[0]) : 0);
    cmp(rq, "ctl", int'(ctl), int'(m_ctl));
    cmp(rq, "overrun", int'(ovr), int'(m_ov));
  endtask

  task automatic op(input bit pu, input bit lb, input logic [7:0] d, input bit po,
                    input bit cl, input bit we, input logic [7:0] cv, input string rq);
    int cap;
    bit flush, pu_ok, po_ok, rej;
    @(negedge clk);
    push = pu; lpbk = lb; pdata = d; pop = po; clr = cl; ctl_we = we; ctl_d = cv;
    cap   = m_ctl[0] ? DP : 1;
    flush = we && ((cv[0] != m_ctl[0]) || (cv[0] && cv[1]));
    rej   = pu && !flush && (mq.size() >= cap);
    pu_ok = pu && !flush && (mq.size() < cap);
    po_ok = po && !flush && (mq.size() > 0);
    if (flush) mq.delete();
    else begin
      if (po_ok) void'(mq.pop_front());
      if (pu_ok) mq.push_back(d);
    end
    if (rej && lb) m_ov = 1;
    else if (cl) m_ov = 0;
    if (we) m_ctl = cv[0] ? (cv & 8'hC9) : 8'h00;
    @(posedge clk);
    #1;
    push = 0; lpbk = 0; pop = 0; clr = 0; ctl_we = 0;
    chk(rq);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 chk("R1");
    rst_n = 1'b1;
    #1 chk("R1");

    // single-entry mode
    op(1, 0, 8'h11, 0, 0, 0, 0, "R2");
    op(1, 0, 8'h22, 0, 0, 0, 0, "R7");
    op(1, 0, 8'h23, 1, 0, 0, 0, "R7");
    op(1, 1, 8'h33, 0, 0, 0, 0, "R8");
    op(0, 0, 8'h00, 0, 1, 0, 0, "R8");
    op(1, 1, 8'h34, 0, 1, 0, 0, "R8");
    op(0, 0, 8'h00, 0, 1, 0, 0, "R8");
    op(0, 0, 8'h00, 0, 0, 0, 0, "R9");
    op(0, 0, 8'h00, 0, 0, 0, 0, "R9");
    op(0, 0, 8'h00, 1, 0, 0, 0, "R9");

    // every control byte, each flush seen from both modes
    for (int v = 0; v < 256; v++) begin
      op(1, 0, 8'(v), 0, 0, 0, 0, "R3");
      op(0, 0, 8'h00, 0, 0, 1, 8'(v), v[0] ? "R6" : "R4");
    end

    // FIFO mode fill, full, hold, reset
    op(0, 0, 8'h00, 0, 0, 1, 8'h01, "R3");
    for (int i = 0; i < DP; i++) op(1, 0, 8'(8'h40 + i), 0, 0, 0, 0, "R2");
    op(1, 1, 8'hEE, 1, 0, 0, 0, "R7");
    op(1, 0, 8'h50, 0, 0, 0, 0, "R10");
    op(0, 0, 8'h00, 0, 0, 1, 8'hC9, "R12");
    op(0, 0, 8'h00, 0, 0, 1, 8'h41, "R12");
    op(0, 0, 8'h00, 1, 0, 0, 0, "R10");
    op(0, 0, 8'h00, 0, 0, 1, 8'h03, "R5");
    for (int i = 0; i < 2; i++) op(1, 0, 8'(8'h60 + i), 0, 0, 0, 0, "R11");
    for (int i = 0; i < 10; i++) op(1, 0, 8'(8'h70 + i), 1, 0, 0, 0, "R11");
    op(1, 0, 8'h99, 1, 0, 1, 8'h00, "R3");
    op(1, 0, 8'h5A, 0, 0, 0, 0, "R3");
    op(1, 0, 8'h98, 1, 0, 1, 8'h01, "R3");

    // pseudo-random sweep
    for (int i = 0; i < 3000; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      op(lf[0] | lf[1], lf[3], {lf[7:0] ^ lf[15:8]}, lf[2], lf[4] & lf[5],
         (lf[9:6] == 4'h0), lf[15:8], "R10");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule